// File: doc/BRIEF.md
# Time Base Periodic Interrupt Timer

This block raises a periodic interrupt request. A divider chain runs all the time. One of its taps is chosen by a 3-bit select code, and the block signals each falling edge of that tap. There are two chains. The first counts every cycle of the fast gear clock, which is also the system clock of the block. The second counts rising edges of a slow low-frequency clock, which is brought into the gear domain through a two-flop synchronizer. A 2-bit clock-mode input picks which chain feeds the tap multiplexer and which select codes are legal.

Software controls the block through a byte-wide control register that it can write and read. The register holds an enable bit and the select code. While the enable bit is set, every falling edge of the selected tap produces a single-cycle request pulse. The chains never stop or reset when the enable changes, so the first request after enabling arrives at the next falling edge of the tap, which is sooner than one full period. A STOP-entry strobe clears the enable in hardware. The select code is meant to be changed only while the block is disabled. A change while enabled may produce one misplaced request.

There is no data stream here, so there is no valid/ready interface. Every pin is a plain control or status signal.

Top module: `tbase_irq_timer`

## Requirements
- R1: With clk_mode = 2'b00 (fast source), the request period in gear cycles is 2^(E-FAST_TRIM). E is 22, 20, 15, 13, 12, 11, 10 and 8 for select codes 0 to 7.
- R2: With clk_mode = 2'b01 (slow source), the request period in slow-clock rising edges is 2^(E-SLOW_TRIM). E is 15, 13, 8, 6, 5, 4 and 3 for codes 0 to 6. Code 7 is reserved and never raises irq.
- R3: With clk_mode = 2'b10 or 2'b11 (slow-only operation), only codes 0 and 1 are valid, with the periods of R2. Codes 2 to 7 are reserved and never raise irq.
- R4: While enabled, irq is high for exactly one gear cycle per falling edge of the selected tap.
- R5: While the enable bit is 0, irq stays low.
- R6: Both divider chains keep counting while the block is disabled. Requests after re-enabling keep the phase of the requests before.
- R7: The first request after enabling comes at the next falling edge of the tap. That is less than one period after the enable write when the tap was already high.
- R8: A one-cycle stop_req clears the enable bit. If stop_req and a register write fall in the same cycle, the select code is written and the enable still ends up 0.
- R9: Control register layout: bit 3 is the enable, bits 2:0 are the select code, and bits 7:4 always read 0. The register resets to 0x00. A write takes effect at the next clock edge, and rd_data shows the register contents directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gear clock; system clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_slow | input | 1 | Low-frequency clock, sampled into the gear domain |
| clk_mode | input | 2 | 00 fast source, 01 slow source, 1x slow-only |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data: bit 3 enable, bits 2:0 select |
| rd_data | output | 8 | Control register read-back |
| stop_req | input | 1 | STOP-entry strobe; clears the enable |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The bench builds the block with FAST_TRIM = 7 and SLOW_TRIM = 2. The slow clock runs at six gear cycles per period. With these values the longest fast tap (32768 cycles) and every slow tap down to two slow edges fit in a short run, so the bench measures exact periods for all eight fast codes and for the slow codes. Reserved codes in both slow modes are watched for silence, and the phase tests for disable and re-enable run at periods of 8 and 64 cycles.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 1 << SEL_W;
  localparam int REG_W    = 8;

  typedef enum logic [1:0] {
    SRC_FAST      = 2'b00,
    SRC_SLOW      = 2'b01,
    SRC_SLOWONLY  = 2'b10,
    SRC_SLOWONLY2 = 2'b11
  } src_mode_e;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Untrimmed divide exponent of each fast tap.
  function automatic int fast_exp(input int code);
    case (code)
      0:       return 22;
      1:       return 20;
      2:       return 15;
      3:       return 13;
      4:       return 12;
      5:       return 11;
      6:       return 10;
      default: return 8;
    endcase
  endfunction

  // Untrimmed divide exponent of each slow tap; 0 marks a reserved code.
  function automatic int slow_exp(input int code);
    case (code)
      0:       return 15;
      1:       return 13;
      2:       return 8;
      3:       return 6;
      4:       return 5;
      5:       return 4;
      6:       return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic code_legal(input src_mode_e m, input logic [SEL_W-1:0] s);
    case (m)
      SRC_FAST: return 1'b1;
      SRC_SLOW: return (slow_exp(int'(s)) != 0);
      default:  return (s <= 3'd1);
    endcase
  endfunction

endpackage

// File: rtl/tbt_ctrl_reg.sv
module tbt_ctrl_reg
  import tbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             stop_req,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rd_data
);

  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[REG_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_en) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      // STOP entry has the last word on the enable.
      if (stop_req) ctrl.en <= 1'b0;
    end
  end

  assign rd_data = {{(REG_W-CTRL_W){1'b0}}, ctrl};

endmodule

// File: rtl/tbt_divider.sv
module tbt_divider #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= count + 1'b1;
  end

endmodule

// File: rtl/tbt_slow_sync.sv
module tbt_slow_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_slow,
  output logic tick
);

  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= clk_slow;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign tick = sync_q & ~last_q;

endmodule

// File: rtl/tbt_tap_select.sv
module tbt_tap_select
  import tbt_pkg::*;
#(
  parameter int FAST_TRIM = 0,
  parameter int SLOW_TRIM = 0,
  parameter int FAST_W    = 22,
  parameter int SLOW_W    = 15
) (
  input  logic [FAST_W-1:0] fast_cnt,
  input  logic [SLOW_W-1:0] slow_cnt,
  input  src_mode_e         mode,
  input  logic [SEL_W-1:0]  sel,
  output logic              tap
);

  logic [NUM_TAPS-1:0] fast_taps;
  logic [NUM_TAPS-1:0] slow_taps;
  logic                unused_cnt_bits;

  assign unused_cnt_bits = ^{fast_cnt, slow_cnt};

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_taps
    assign fast_taps[i] = fast_cnt[fast_exp(i) - FAST_TRIM - 1];
    if (slow_exp(i) != 0) begin : g_slow
      assign slow_taps[i] = slow_cnt[slow_exp(i) - SLOW_TRIM - 1];
    end else begin : g_rsvd
      assign slow_taps[i] = 1'b0;
    end
  end

  always_comb begin
    if (!code_legal(mode, sel))  tap = 1'b0;
    else if (mode == SRC_FAST)   tap = fast_taps[sel];
    else                         tap = slow_taps[sel];
  end

endmodule

// File: rtl/tbt_edge_irq.sv
module tbt_edge_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tap,
  input  logic en,
  output logic irq
);

  logic tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      tap_q <= tap;
      irq   <= en & tap_q & ~tap;
    end
  end

endmodule

// File: rtl/tbase_irq_timer.sv
module tbase_irq_timer
  import tbt_pkg::*;
#(
  parameter int FAST_TRIM = 0,
  parameter int SLOW_TRIM = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_slow,
  input  logic [1:0]       clk_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             stop_req,
  output logic             irq
);

  localparam int FAST_W = fast_exp(0) - FAST_TRIM;
  localparam int SLOW_W = slow_exp(0) - SLOW_TRIM;

  ctrl_t             ctrl;
  logic              slow_tick;
  logic              tap;
  logic [FAST_W-1:0] fast_cnt;
  logic [SLOW_W-1:0] slow_cnt;

  tbt_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .stop_req (stop_req),
    .ctrl     (ctrl),
    .rd_data  (rd_data)
  );

  tbt_divider #(.W(FAST_W)) u_fast_div (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (1'b1),
    .count (fast_cnt)
  );

  tbt_slow_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_slow (clk_slow),
    .tick     (slow_tick)
  );

  tbt_divider #(.W(SLOW_W)) u_slow_div (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (slow_tick),
    .count (slow_cnt)
  );

  tbt_tap_select #(
    .FAST_TRIM (FAST_TRIM),
    .SLOW_TRIM (SLOW_TRIM),
    .FAST_W    (FAST_W),
    .SLOW_W    (SLOW_W)
  ) u_tap (
    .fast_cnt (fast_cnt),
    .slow_cnt (slow_cnt),
    .mode     (src_mode_e'(clk_mode)),
    .sel      (ctrl.sel),
    .tap      (tap)
  );

  tbt_edge_irq u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .tap   (tap),
    .en    (ctrl.en),
    .irq   (irq)
  );

endmodule

// File: rtl/tbt_checker.sv
module tbt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] clk_mode,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       stop_req,
  input logic       irq
);

  logic rsvd;
  assign rsvd = (clk_mode == 2'b01 && rd_data[2:0] == 3'd7) ||
                (clk_mode[1] && rd_data[2:0] > 3'd1);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3] |=> !irq);

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !rd_data[3]);

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stop_req) |=> (rd_data[3:0] == $past(wr_data[3:0])));

  p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsvd && $past(rsvd)) |=> !irq);

endmodule

bind tbase_irq_timer tbt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_mode (clk_mode),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .stop_req (stop_req),
  .irq      (irq)
);

// File: tb/test_tbase_irq_timer.sv
module test_tbase_irq_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_slow = 1'b0;
  logic [1:0] clk_mode = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       stop_req = 1'b0;
  logic       irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (3) @(negedge clk);
    clk_slow = ~clk_slow;
  end

  tbase_irq_timer #(.FAST_TRIM(7), .SLOW_TRIM(2)) i_tbase_irq_timer (
    .clk(clk), .rst_n(rst_n), .clk_slow(clk_slow), .clk_mode(clk_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .stop_req(stop_req), .irq(irq)
  );

  // {mode[1:0], sel[2:0], period in gear cycles (0 = must stay silent)}
  localparam int NV = 18;
  localparam logic [24:0] VEC [NV] = '{
    {2'b00, 3'd0, 20'd32768}, {2'b00, 3'd1, 20'd8192}, {2'b00, 3'd2, 20'd256},
    {2'b00, 3'd3, 20'd64},    {2'b00, 3'd4, 20'd32},   {2'b00, 3'd5, 20'd16},
    {2'b00, 3'd6, 20'd8},     {2'b00, 3'd7, 20'd2},
    {2'b01, 3'd2, 20'd384},   {2'b01, 3'd3, 20'd96},   {2'b01, 3'd4, 20'd48},
    {2'b01, 3'd5, 20'd24},    {2'b01, 3'd6, 20'd12},   {2'b01, 3'd7, 20'd0},
    {2'b10, 3'd1, 20'd12288}, {2'b10, 3'd2, 20'd0},    {2'b10, 3'd5, 20'd0},
    {2'b11, 3'd7, 20'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output bit found, output int t);
    found = 1'b0; t = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (irq) begin found = 1'b1; t = cyc; break; end
    end
  endtask

  task automatic count_irq(input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq) hits++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    finish_run();
  end

  initial begin
    bit found; int t0, t1, te, hits; int per;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(rd_data == 8'h00, "R9 reset rd_data", rd_data, 0);
    check(irq == 1'b0, "R9 reset irq", irq, 0);
    // R9: upper bits read zero
    write_reg(8'hFF);
    check(rd_data == 8'h0F, "R9 readback", rd_data, 8'h0F);
    write_reg(8'h07);
    @(negedge clk);
    // R5: disabled, fastest tap, silent
    count_irq(100, hits);
    check(hits == 0, "R5 disabled silent", hits, 0);

    // R1 R2 R3 R4: table walk
    for (int v = 0; v < NV; v++) begin
      per = int'(VEC[v][19:0]);
      write_reg({5'b0, VEC[v][22:20]});
      clk_mode = VEC[v][24:23];
      repeat (3) @(negedge clk);
      write_reg({5'b01, VEC[v][22:20]});
      if (per == 0) begin
        count_irq(600, hits);
        check(hits == 0, "R3 reserved code silent", hits, 0);
      end else begin
        wait_irq(2 * per + 40, found, t0);
        check(found, "R1/R2 first request", int'(found), 1);
        @(negedge clk);
        check(irq == 1'b0, "R4 single-cycle pulse", irq, 0);
        wait_irq(2 * per + 40, found, t1);
        check(found && (t1 - t0 == per), "R1 R2 R3 period", t1 - t0, per);
      end
      write_reg(8'h00);
    end

    clk_mode = 2'b00;
    // R8: stop clears enable
    write_reg(8'h0F);
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    check(rd_data == 8'h07, "R8 stop clears enable", rd_data, 8'h07);
    @(negedge clk);
    count_irq(50, hits);
    check(hits == 0, "R8 silent after stop", hits, 0);
    // R8: stop beats a simultaneous write
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h0E; stop_req = 1'b1;
    @(negedge clk); wr_en = 1'b0; stop_req = 1'b0;
    check(rd_data == 8'h06, "R8 stop with write", rd_data, 8'h06);

    // R6: phase kept across disable (period 8)
    write_reg(8'h0E);
    wait_irq(40, found, t0);
    write_reg(8'h06);
    repeat (37) @(negedge clk);
    write_reg(8'h0E);
    wait_irq(40, found, t1);
    check(found && ((t1 - t0) % 8 == 0), "R6 free-running phase", (t1 - t0) % 8, 0);

    // R7: short first interval (period 64)
    write_reg(8'h0B);
    wait_irq(200, found, t0);
    write_reg(8'h03);
    while (cyc < t0 + 84) @(negedge clk);
    te = cyc;
    write_reg(8'h0B);
    wait_irq(200, found, t1);
    check(found && (t1 == t0 + 128), "R7 first request at tap edge", t1 - t0, 128);
    check(t1 - te < 64, "R7 first interval short", t1 - te, 63);

    finish_run();
  end

endmodule